// File: doc/BRIEF.md
# Indirect PCI Configuration Access Port

This block lets a host reach PCI configuration space through two registers. The host first writes a configuration address word. That word holds an enable bit and the target bus, device, function and dword register number. The register number includes the extended bits. The host then reads or writes a data register that sits one dword above the address register. That data access starts a single configuration transaction on a simple request/response interface toward the link logic. The host access stalls until the response returns.

A status register holds the local bus and device numbers, which software can program, and a live link-down flag. On the local bus only the local device and one peer device can exist. The peer is device 1 when the local device is 0, and device 0 otherwise. An access to any other device on the local bus is answered inside the block with an error and never goes downstream. An access made while the enable bit is clear also completes locally.

Top module: `cfg_access_port`

## Requirements
- R1: A write to the address register (offset 0x00) stores the enable bit 31, extended register bits 27:24, bus 23:16, device 15:11, function 10:8 and dword register 7:2. Bits 30:28 and 1:0 always read back as zero. Reset leaves the register at zero.
- R2: The data register sits at offset 0x04, exactly four bytes above the address register. Only accesses at that offset start configuration transactions.
- R3: The status register (offset 0x10) holds the local bus in bits 15:8 and the local device in bits 20:16. Both fields are writable and reset to zero. Bit 0 reads as the inverse of `link_up`, is not stored, and ignores writes. All other status bits read zero.
- R4: An access is filtered when the target bus equals the local bus, the target device differs from the local device, and the target device is not the allowed peer. The allowed peer is device 1 when the local device is 0, and device 0 otherwise. Targets on any other bus are never filtered.
- R5: A filtered read completes in the cycle it is presented, with data 0xFFFFFFFF and `host_err` high. A filtered write completes the same way and is discarded. Neither issues a downstream request.
- R6: A data access made while the enable bit is clear completes in the cycle it is presented. A read returns 0xFFFFFFFF. `host_err` is low and no downstream request is issued.
- R7: An enabled, unfiltered data access issues exactly one downstream request. The request carries the stored address word as `dn_req_addr`, the write flag and the write data.
- R8: `host_ready` stays low from the start of a forwarded access until the response arrives. The access then completes in the response cycle with `dn_rsp_data` and `dn_rsp_err`. The request fields hold steady while `dn_req_ready` is low. With no backpressure and a two-cycle response, completion comes three cycles after the access is presented.
- R9: During and after reset no downstream request is pending, and the address and status fields read zero.
- R10: Accesses to the address register, the status register or an unmapped offset complete in the cycle presented with `host_err` low. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link present indication |
| host_valid | input | 1 | Host access request, held until `host_ready` |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Host access completes this cycle |
| host_rdata | output | 32 | Host read data, valid with `host_ready` |
| host_err | output | 1 | Host access completed with an error |
| dn_req_valid | output | 1 | Downstream configuration request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_req_addr | output | 32 | Packed configuration address word |
| dn_req_we | output | 1 | Downstream request is a write |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_data | input | 32 | Downstream read data |
| dn_rsp_err | input | 1 | Downstream response error |

## Verification
Two functions can fall in the same cycle: a software write to the status register and a change of `link_up`. The bench toggles `link_up` on the same edge at which it presents a status write that also drives bit 0. It then reads the status back. The stored bus and device must show the written values, and bit 0 must show only the new live link state. The filter is judged against a behavioural reference model that is recomputed at every data access. Request fields are compared on every clock while a request is pending.

// File: rtl/cfg_port_pkg.sv
// Shared types for the indirect configuration access port.
// Assumes a 32-bit host data path and fixed field placement in the
// configuration address word and the status word.
package cfg_port_pkg;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int DW_W   = 6;
    localparam int EXT_W  = 4;

    // Configuration address word, bit 31 down to bit 0
    typedef struct packed {
        logic             en;
        logic [2:0]       rsvd_hi;
        logic [EXT_W-1:0] ext;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [DW_W-1:0]  dw;
        logic [1:0]       rsvd_lo;
    } cfg_addr_t;

    // Status word, bit 31 down to bit 0
    typedef struct packed {
        logic [10:0]      rsvd_hi;
        logic [DEV_W-1:0] dev;
        logic [BUS_W-1:0] bus;
        logic [6:0]       rsvd_lo;
        logic             link_down;
    } cfg_stat_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_REQ  = 2'd1,
        XS_RSP  = 2'd2
    } xact_state_t;

    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    // Clears the reserved bits of a host-written address word
    function automatic cfg_addr_t scrub_addr(input logic [WORD_W-1:0] w);
        cfg_addr_t a;
        a = cfg_addr_t'(w);
        a.rsvd_hi = '0;
        a.rsvd_lo = '0;
        return a;
    endfunction
endpackage

// File: rtl/cfg_regs.sv
// Address and status registers of the configuration access port, with
// the read-data multiplexer for the non-data offsets.
// Assumes the caller qualifies wr_en with host_valid and host_we.
module cfg_regs
    import cfg_port_pkg::*;
#(
    parameter int                 HOST_AW  = 8,
    parameter logic [HOST_AW-1:0] ADDR_OFF = '0,
    parameter logic [HOST_AW-1:0] STAT_OFF = HOST_AW'(16)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [HOST_AW-1:0] acc_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               link_up,
    output cfg_addr_t          addr_q,
    output logic [BUS_W-1:0]   loc_bus,
    output logic [DEV_W-1:0]   loc_dev,
    output logic [WORD_W-1:0]  reg_rdata
);
    logic      wr_addr_reg;
    logic      wr_stat_reg;
    cfg_stat_t wr_stat;
    cfg_stat_t stat_view;

    assign wr_addr_reg = wr_en && (acc_addr == ADDR_OFF);
    assign wr_stat_reg = wr_en && (acc_addr == STAT_OFF);
    assign wr_stat     = cfg_stat_t'(wr_data);

    // Holds the configuration address word written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_addr_reg) begin
            addr_q <= scrub_addr(wr_data);
        end
    end

    // Holds the programmable local bus and device numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_bus <= '0;
            loc_dev <= '0;
        end else if (wr_stat_reg) begin
            loc_bus <= wr_stat.bus;
            loc_dev <= wr_stat.dev;
        end
    end

    // Assembles the status view with the live link indication
    always_comb begin
        stat_view           = '0;
        stat_view.dev       = loc_dev;
        stat_view.bus       = loc_bus;
        stat_view.link_down = !link_up;
    end

    // Selects read data for the address, status and unmapped offsets
    always_comb begin
        if (acc_addr == ADDR_OFF) begin
            reg_rdata = addr_q;
        end else if (acc_addr == STAT_OFF) begin
            reg_rdata = stat_view;
        end else begin
            reg_rdata = '0;
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr_reg |=> $stable(addr_q)); // R1
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_reg |=> ($stable(loc_bus) && $stable(loc_dev))); // R3
endmodule

// File: rtl/cfg_bdf_filter.sv
// Decides whether a configuration target cannot exist on the local bus.
// Assumes only the local device and one peer live on the local bus.
// FILTER_EN = 0 builds a pass-through variant that never filters.
module cfg_bdf_filter
    import cfg_port_pkg::*;
#(
    parameter bit FILTER_EN = 1'b1
) (
    input  logic [BUS_W-1:0] tgt_bus,
    input  logic [DEV_W-1:0] tgt_dev,
    input  logic [BUS_W-1:0] loc_bus,
    input  logic [DEV_W-1:0] loc_dev,
    output logic             blocked
);
    generate
        if (FILTER_EN) begin : g_filter
            logic             on_local_bus;
            logic             is_self;
            logic [DEV_W-1:0] peer_dev;

            // Derives the single peer permitted beside the local device
            always_comb begin
                on_local_bus = (tgt_bus == loc_bus);
                is_self      = (tgt_dev == loc_dev);
                peer_dev     = (loc_dev == '0) ? DEV_W'(1) : '0;
                blocked      = on_local_bus && !is_self && (tgt_dev != peer_dev);
            end
        end else begin : g_pass
            assign blocked = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfg_xact_fsm.sv
// Sequences one data-register access. Disabled or filtered accesses
// complete locally in the cycle presented. Others issue one downstream
// request and stall the host until the response arrives.
// Assumes the host holds its access until completion.
module cfg_xact_fsm
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              acc_we,
    input  logic [WORD_W-1:0] acc_wdata,
    input  cfg_addr_t         cfg,
    input  logic              blocked,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [WORD_W-1:0] dn_req_addr,
    output logic              dn_req_we,
    output logic [WORD_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    input  logic [WORD_W-1:0] dn_rsp_data,
    input  logic              dn_rsp_err,
    output logic              done,
    output logic [WORD_W-1:0] done_rdata,
    output logic              done_err
);
    xact_state_t state;
    logic        forward;

    assign forward      = start && cfg.en && !blocked;
    assign dn_req_valid = (state == XS_REQ);

    // Advances the transaction state and captures the request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= XS_IDLE;
            dn_req_addr  <= '0;
            dn_req_we    <= 1'b0;
            dn_req_wdata <= '0;
        end else begin
            case (state)
                XS_IDLE: if (forward) begin
                    state        <= XS_REQ;
                    dn_req_addr  <= cfg;
                    dn_req_we    <= acc_we;
                    dn_req_wdata <= acc_wdata;
                end
                XS_REQ:  if (dn_req_ready) state <= XS_RSP;
                XS_RSP:  if (dn_rsp_valid) state <= XS_IDLE;
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Produces the host completion for local and forwarded accesses
    always_comb begin
        done       = 1'b0;
        done_rdata = '0;
        done_err   = 1'b0;
        case (state)
            XS_IDLE: if (start && !forward) begin
                done       = 1'b1;
                done_rdata = ALL_ONES;
                done_err   = cfg.en;
            end
            XS_RSP: if (dn_rsp_valid) begin
                done       = 1'b1;
                done_rdata = dn_rsp_data;
                done_err   = dn_rsp_err;
            end
            default: ;
        endcase
    end

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr)
            && $stable(dn_req_we) && $stable(dn_req_wdata))); // R8
    AST_LOCAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == XS_IDLE) && start && (!cfg.en || blocked)) |=> !dn_req_valid); // R5
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready) |=> !dn_req_valid); // R7
    AST_STALL_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !done); // R8
endmodule

// File: rtl/cfg_access_port.sv
// Top of the indirect configuration access port. Decodes host offsets,
// routes data-register accesses to the transaction sequencer and other
// offsets to the register block.
// Assumes one host access at a time, held until host_ready.
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int                 HOST_AW      = 8,
    parameter logic [HOST_AW-1:0] ADDR_REG_OFF = '0,
    parameter logic [HOST_AW-1:0] STAT_REG_OFF = HOST_AW'(16)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_up,
    input  logic               host_valid,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic               host_ready,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               host_err,
    output logic               dn_req_valid,
    input  logic               dn_req_ready,
    output logic [WORD_W-1:0]  dn_req_addr,
    output logic               dn_req_we,
    output logic [WORD_W-1:0]  dn_req_wdata,
    input  logic               dn_rsp_valid,
    input  logic [WORD_W-1:0]  dn_rsp_data,
    input  logic               dn_rsp_err
);
    localparam logic [HOST_AW-1:0] DATA_REG_OFF = ADDR_REG_OFF + HOST_AW'(4);

    logic              data_sel;
    logic              xact_start;
    logic              reg_wr;
    cfg_addr_t         addr_q;
    logic [BUS_W-1:0]  loc_bus;
    logic [DEV_W-1:0]  loc_dev;
    logic [WORD_W-1:0] reg_rdata;
    logic              blocked;
    logic              xact_done;
    logic [WORD_W-1:0] xact_rdata;
    logic              xact_err;

    assign data_sel   = (host_addr == DATA_REG_OFF);
    assign xact_start = host_valid && data_sel;
    assign reg_wr     = host_valid && host_we && !data_sel;

    cfg_regs #(
        .HOST_AW  (HOST_AW),
        .ADDR_OFF (ADDR_REG_OFF),
        .STAT_OFF (STAT_REG_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .acc_addr  (host_addr),
        .wr_data   (host_wdata),
        .link_up   (link_up),
        .addr_q    (addr_q),
        .loc_bus   (loc_bus),
        .loc_dev   (loc_dev),
        .reg_rdata (reg_rdata)
    );

    cfg_bdf_filter #(
        .FILTER_EN (1'b1)
    ) u_filter (
        .tgt_bus (addr_q.bus),
        .tgt_dev (addr_q.dev),
        .loc_bus (loc_bus),
        .loc_dev (loc_dev),
        .blocked (blocked)
    );

    cfg_xact_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (xact_start),
        .acc_we       (host_we),
        .acc_wdata    (host_wdata),
        .cfg          (addr_q),
        .blocked      (blocked),
        .dn_req_valid (dn_req_valid),
        .dn_req_ready (dn_req_ready),
        .dn_req_addr  (dn_req_addr),
        .dn_req_we    (dn_req_we),
        .dn_req_wdata (dn_req_wdata),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_data  (dn_rsp_data),
        .dn_rsp_err   (dn_rsp_err),
        .done         (xact_done),
        .done_rdata   (xact_rdata),
        .done_err     (xact_err)
    );

    // Merges the completion of data accesses and register accesses
    always_comb begin
        host_ready = data_sel ? xact_done : 1'b1;
        host_rdata = data_sel ? xact_rdata : reg_rdata;
        host_err   = data_sel && xact_err;
    end

    AST_FILTER_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> ((addr_q.bus == loc_bus) && (addr_q.dev != loc_dev))); // R4
    AST_REG_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !data_sel) |-> (host_ready && !host_err)); // R10
endmodule

// File: tb/cfg_access_port_bench.sv
`timescale 1ns/1ps
module cfg_access_port_bench;
    localparam logic [7:0]  OFF_ADDR = 8'h00;
    localparam logic [7:0]  OFF_DATA = 8'h04;
    localparam logic [7:0]  OFF_STAT = 8'h10;
    localparam logic [31:0] MAGIC    = 32'hA5A5_0000;
    localparam int          LAT      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        host_err;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b1;
    logic [31:0] dn_req_addr;
    logic        dn_req_we;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_data = '0;
    logic        dn_rsp_err = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_addr = '0;
    logic [7:0]  m_bus = '0;
    logic [4:0]  m_dev = '0;
    bit          expect_req = 1'b0;
    logic [31:0] exp_addr = '0;
    bit          exp_we = 1'b0;
    logic [31:0] exp_wd = '0;

    // responder state
    int          acc_count = 0;
    int          hold = 0;
    int          cd = 0;
    logic [31:0] rec_addr = '0;
    bit          rec_we = 1'b0;
    logic [31:0] rec_wd = '0;

    always #10 clk = ~clk;

    cfg_access_port u_cfg_access_port (
        .clk (clk), .rst_n (rst_n), .link_up (link_up),
        .host_valid (host_valid), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_ready (host_ready),
        .host_rdata (host_rdata), .host_err (host_err),
        .dn_req_valid (dn_req_valid), .dn_req_ready (dn_req_ready),
        .dn_req_addr (dn_req_addr), .dn_req_we (dn_req_we),
        .dn_req_wdata (dn_req_wdata), .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_data (dn_rsp_data), .dn_rsp_err (dn_rsp_err)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic bit model_block(input logic [7:0] tb, input logic [7:0] lb,
                                       input logic [4:0] td, input logic [4:0] ld);
        if (tb != lb) return 1'b0;
        if (td == ld) return 1'b0;
        if (ld == 5'd0) return td != 5'd1;
        return td != 5'd0;
    endfunction

    task automatic host_op(input bit we, input logic [7:0] off, input logic [31:0] wd,
                           output logic [31:0] rd, output bit er, output int lat);
        @(negedge clk);
        host_valid = 1'b1; host_we = we; host_addr = off; host_wdata = wd;
        lat = 0;
        #1;
        while (!host_ready && lat <= 60) begin
            @(negedge clk); #1; lat++;
        end
        rd = host_rdata; er = host_err;
        @(negedge clk);
        host_valid = 1'b0; host_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] off, input logic [31:0] exp, input string rq);
        logic [31:0] rd; bit er; int lat;
        host_op(1'b0, off, '0, rd, er, lat);
        chk(rd == exp, rq, rd, exp);
        chk(lat == 0 && !er, "R10 register access immediate", 32'(lat), 32'd0);
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [31:0] wd);
        logic [31:0] rd; bit er; int lat;
        host_op(1'b1, off, wd, rd, er, lat);
    endtask

    task automatic set_addr(input bit en, input logic [3:0] ext, input logic [7:0] bus,
                            input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] dw);
        m_addr = {en, 3'b000, ext, bus, dev, fn, dw, 2'b00};
        reg_wr(OFF_ADDR, m_addr | 32'h7000_0003);
    endtask

    task automatic set_stat(input logic [7:0] bus, input logic [4:0] dev);
        m_bus = bus; m_dev = dev;
        reg_wr(OFF_STAT, {11'h7FF, dev, bus, 8'hFF});
    endtask

    task automatic cfg_op(input bit we, input logic [31:0] wd, input int h, input string rq);
        logic [31:0] rd; bit er; int lat; int n0; bit blk; bit en;
        en  = m_addr[31];
        blk = model_block(m_addr[23:16], m_bus, m_addr[15:11], m_dev);
        n0  = acc_count;
        hold = h;
        if (en && !blk) begin
            expect_req = 1'b1; exp_addr = m_addr; exp_we = we; exp_wd = wd;
        end
        host_op(we, OFF_DATA, wd, rd, er, lat);
        expect_req = 1'b0;
        hold = 0;
        if (!en) begin
            chk(lat == 0, {rq, " R6 disabled immediate"}, 32'(lat), 32'd0);
            chk(!er, {rq, " R6 disabled no error"}, 32'(er), 32'd0);
            if (!we) chk(rd == '1, {rq, " R6 disabled read ones"}, rd, '1);
            chk(acc_count == n0, {rq, " R6 no request"}, 32'(acc_count - n0), 32'd0);
        end else if (blk) begin
            chk(lat == 0, {rq, " R5 filtered immediate"}, 32'(lat), 32'd0);
            chk(er, {rq, " R4 R5 filtered error"}, 32'(er), 32'd1);
            if (!we) chk(rd == '1, {rq, " R5 filtered read ones"}, rd, '1);
            chk(acc_count == n0, {rq, " R5 no request"}, 32'(acc_count - n0), 32'd0);
        end else begin
            chk(acc_count == n0 + 1, {rq, " R7 one request"}, 32'(acc_count - n0), 32'd1);
            chk(rec_addr == m_addr && rec_we == we && (!we || rec_wd == wd),
                {rq, " R7 request fields"}, rec_addr, m_addr);
            chk(lat == 3 + h, {rq, " R8 stall latency"}, 32'(lat), 32'(3 + h));
            chk(er == (m_addr[23:16] == 8'hEE), {rq, " R8 response error"}, 32'(er),
                32'(m_addr[23:16] == 8'hEE));
            if (!we) chk(rd == (m_addr ^ MAGIC), {rq, " R8 response data"}, rd, m_addr ^ MAGIC);
        end
    endtask

    // downstream responder: backpressure, acceptance record, fixed-latency reply
    initial begin
        forever begin
            @(negedge clk);
            dn_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    dn_rsp_valid = 1'b1;
                    dn_rsp_data  = rec_addr ^ MAGIC;
                    dn_rsp_err   = (rec_addr[23:16] == 8'hEE);
                end
            end
            if (dn_req_valid && hold > 0) begin
                dn_req_ready = 1'b0; hold--;
            end else begin
                dn_req_ready = 1'b1;
            end
            if (dn_req_valid && dn_req_ready) begin
                acc_count++;
                rec_addr = dn_req_addr; rec_we = dn_req_we; rec_wd = dn_req_wdata;
                cd = LAT;
            end
        end
    end

    // per-clock comparison of the downstream request against the model
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && !finished && dn_req_valid) begin
                chk(expect_req && dn_req_addr == exp_addr && dn_req_we == exp_we
                    && (!exp_we || dn_req_wdata == exp_wd),
                    "R7 per-cycle request", dn_req_addr, exp_addr);
                chk(!host_ready, "R8 stall while request pending", 32'(host_ready), 32'd0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!dn_req_valid, "R9 no request in reset", 32'(dn_req_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        reg_rd(OFF_ADDR, 32'h0, "R9 address reset");
        reg_rd(OFF_STAT, 32'h0, "R9 status reset");

        // R1 field storage and reserved bits
        reg_wr(OFF_ADDR, 32'hFFFF_FFFF);
        reg_rd(OFF_ADDR, 32'h8FFF_FFFC, "R1 reserved bits clear");
        set_addr(1'b1, 4'hA, 8'h12, 5'h1B, 3'd5, 6'h2D);
        reg_rd(OFF_ADDR, m_addr, "R1 field placement");

        // R10 unmapped offsets
        reg_wr(8'h08, 32'h1234_5678);
        reg_rd(8'h08, 32'h0, "R10 unmapped reads zero");
        reg_rd(8'h0C, 32'h0, "R10 unmapped reads zero");
        reg_rd(OFF_ADDR, m_addr, "R10 unmapped write ignored");
        reg_rd(OFF_STAT, 32'h0, "R10 unmapped write ignored");

        // R3 status fields, then a status write coinciding with a link change
        reg_wr(OFF_STAT, 32'hFFFF_FFFF);
        m_bus = 8'hFF; m_dev = 5'h1F;
        reg_rd(OFF_STAT, 32'h001F_FF00, "R3 status writable fields");
        fork
            begin
                logic [31:0] rd; bit er; int lat;
                host_op(1'b1, OFF_STAT, 32'h0003_0500, rd, er, lat);
            end
            begin
                @(negedge clk); link_up = 1'b0;
            end
        join
        m_bus = 8'h05; m_dev = 5'h03;
        reg_rd(OFF_STAT, 32'h0003_0501, "R3 write with link change");
        link_up = 1'b1;
        reg_rd(OFF_STAT, 32'h0003_0500, "R3 live link bit");

        // R6 disabled accesses
        set_stat(8'h00, 5'd0);
        set_addr(1'b0, 4'h0, 8'h00, 5'd5, 3'd0, 6'h00);
        cfg_op(1'b0, '0, 0, "R6 read");
        cfg_op(1'b1, 32'h1111_2222, 0, "R6 write");

        // R2 R7 R8 local device 0
        set_addr(1'b1, 4'h0, 8'h00, 5'd0, 3'd0, 6'h04);
        cfg_op(1'b0, '0, 0, "R2 own device read");
        set_addr(1'b1, 4'h3, 8'h00, 5'd1, 3'd2, 6'h11);
        cfg_op(1'b1, 32'hCAFE_F00D, 0, "R7 peer write");
        set_addr(1'b1, 4'h0, 8'h00, 5'd2, 3'd0, 6'h00);
        cfg_op(1'b0, '0, 0, "R4 dev2 read");
        cfg_op(1'b1, 32'hDEAD_BEEF, 0, "R4 dev2 write");
        set_addr(1'b1, 4'h0, 8'h00, 5'd31, 3'd7, 6'h3F);
        cfg_op(1'b0, '0, 0, "R4 dev31");

        // R4 local device nonzero
        set_stat(8'h00, 5'd3);
        set_addr(1'b1, 4'h0, 8'h00, 5'd0, 3'd0, 6'h01);
        cfg_op(1'b0, '0, 0, "R4 peer dev0");
        set_addr(1'b1, 4'h0, 8'h00, 5'd1, 3'd0, 6'h01);
        cfg_op(1'b0, '0, 0, "R4 dev1 filtered");
        set_addr(1'b1, 4'h0, 8'h00, 5'd3, 3'd1, 6'h02);
        cfg_op(1'b0, '0, 0, "R4 own dev3");
        set_addr(1'b1, 4'h0, 8'h00, 5'd4, 3'd0, 6'h00);
        cfg_op(1'b1, 32'h5555_AAAA, 0, "R4 dev4 filtered");

        // other buses, extended register bits, response error
        set_addr(1'b1, 4'hF, 8'h07, 5'd9, 3'd6, 6'h20);
        cfg_op(1'b0, '0, 0, "R4 remote bus");
        set_addr(1'b1, 4'h1, 8'hEE, 5'd2, 3'd0, 6'h08);
        cfg_op(1'b0, '0, 0, "R8 error response");

        // R8 backpressure
        set_addr(1'b1, 4'h2, 8'h03, 5'd0, 3'd0, 6'h10);
        cfg_op(1'b1, 32'h0BAD_CAFE, 4, "R8 backpressure write");
        cfg_op(1'b0, '0, 2, "R8 backpressure read");

        // R4 programmable local bus
        set_stat(8'h22, 5'd0);
        set_addr(1'b1, 4'h0, 8'h22, 5'd1, 3'd0, 6'h00);
        cfg_op(1'b0, '0, 0, "R4 new local bus peer");
        set_addr(1'b1, 4'h0, 8'h22, 5'd6, 3'd0, 6'h00);
        cfg_op(1'b0, '0, 0, "R4 new local bus filtered");
        set_addr(1'b1, 4'h0, 8'h00, 5'd6, 3'd0, 6'h00);
        cfg_op(1'b0, '0, 0, "R4 old bus now remote");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule